// File: doc/BRIEF.md
# Four-Channel DMA Control Register File

This block is the processor-facing control side of a four-channel DMA engine. It decodes a chip select, read and write strobes and a four-bit register address. From that decode it keeps the command register, one mode field per channel, the software request bits, the per-channel mask bits, the terminal-count status flags, the temporary data byte and the low/high byte pointer. It also runs the three software commands that act on the write strobe alone: clear byte pointer, master clear and clear all masks.

Each channel brings in a terminal-count pulse, an external end-of-process pulse, an autoinitialize flag and its raw request line. The block drives one gated request per channel toward the arbiter. A channel's mask bit also sets itself when that channel ends a transfer without autoinitialize, so a finished channel stops asking for service until software enables it again. The address and count counters, the transfer timing sequencer and the arbitration sit outside this block. An access to any address with A3 low is treated as a counter access, and its only effect here is to toggle the byte pointer.

Top module: `dmac_regs`

## Requirements
- R1: A synchronous reset, or a write to address 0xD whatever the data, sets all four mask bits. It clears the command, software request, status terminal-count bits, temporary register and byte pointer, and pulses `idle_pulse` high for one cycle.
- R2: A write to address 0xA changes one mask bit. Data bits 1:0 select the channel, bit 2 gives the new value (1 masks, 0 unmasks), and bits 7:3 have no effect.
- R3: A write to address 0xF loads all four mask bits from data bits 3:0. A write to address 0xE clears all four mask bits whatever the data.
- R4: A terminal-count or external end-of-process pulse on a channel whose `ch_autoinit` is low sets that channel's mask bit at the next clock. With `ch_autoinit` high the mask bit is left unchanged.
- R5: Each bit of `dreq_masked` equals (raw request OR software request) AND NOT mask, taken from the values one clock earlier.
- R6: A write to address 0x9 changes one software request bit. Data bits 1:0 select the channel, bit 2 gives the value, and the other bits have no effect.
- R7: A read of address 0x8 returns the read data one clock after the strobe. Bits 7:4 hold the pending requests (raw OR software request) and bits 3:0 hold the terminal-count flags.
- R8: Status bit n sets on a terminal-count or external end-of-process pulse on channel n. Each status read clears bits 3:0 after their value has been returned. An event in the same cycle as the read is kept for the next read.
- R9: Each `xfer_vld` pulse loads `xfer_byte` into the temporary register. A read of address 0xD returns it and does not change it.
- R10: Every read or write with A3 low toggles `byte_ptr`. A write to address 0xC clears `byte_ptr` whatever the data.
- R11: Reads of addresses 0x0–0x7, 0x9, 0xA, 0xB, 0xC, 0xE and 0xF return 0x00 and leave mask, request and status unchanged. Only the A3-low reads change state, and only `byte_ptr` (R10).
- R12: A write to address 0xB stores data bits 7:2 as the mode field of the channel selected by data bits 1:0, visible on `mode_bus` at bits [6n+5:6n].
- R13: A write to address 0x8 loads the full data byte into the command register, visible on `cmd_q` one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low, one access per low cycle |
| wr_n | input | 1 | Write strobe, active low, one access per low cycle |
| addr | input | 4 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data, 0x00 when no read |
| ch_tc | input | 4 | Per-channel terminal-count pulse |
| ch_eop | input | 4 | Per-channel external end-of-process pulse |
| ch_autoinit | input | 4 | Per-channel autoinitialize flag |
| dreq_raw | input | 4 | Raw per-channel request lines |
| xfer_vld | input | 1 | Memory-to-memory byte moved this cycle |
| xfer_byte | input | 8 | Byte moved |
| dreq_masked | output | 4 | Gated per-channel requests, registered |
| cmd_q | output | 8 | Command register |
| mode_bus | output | 24 | Four 6-bit mode fields, channel 0 lowest |
| byte_ptr | output | 1 | Low/high byte pointer |
| idle_pulse | output | 1 | One-cycle pulse after reset or master clear |

## Verification
The checker assumes that no cycle asserts both strobes with chip select low. A cycle with both strobes low is decoded as a write, and the checker's read-side properties would then misread it. The checker also assumes that terminal-count and end-of-process inputs are clean single-cycle pulses. The bench drives every strobe for exactly one cycle on the falling edge and never overlaps reads with writes. It changes the channel event inputs only between accesses, except in the one case that deliberately lines up an event with a status read.

// File: rtl/dmac_pkg.sv
package dmac_pkg;

  typedef enum logic [3:0] {
    RA_STAT_CMD  = 4'h8,
    RA_REQ       = 4'h9,
    RA_SMASK     = 4'hA,
    RA_MODE      = 4'hB,
    RA_PTR_CLR   = 4'hC,
    RA_TEMP_MCLR = 4'hD,
    RA_MASK_CLR  = 4'hE,
    RA_MASK_ALL  = 4'hF
  } reg_addr_e;

  typedef struct packed {
    logic cmd_wr;
    logic req_wr;
    logic smask_wr;
    logic mode_wr;
    logic ptr_clr;
    logic mclr;
    logic mask_clr;
    logic mask_all_wr;
    logic stat_rd;
    logic temp_rd;
    logic chan_acc;
  } strobe_t;

endpackage

// File: rtl/dmac_decode.sv
module dmac_decode
  import dmac_pkg::*;
(
  input  logic       cs_n,
  input  logic       rd_n,
  input  logic       wr_n,
  input  logic [3:0] addr,
  output strobe_t    stb
);

  logic wr_act;
  logic rd_act;
  reg_addr_e code;

  assign wr_act = !cs_n && !wr_n;
  assign rd_act = !cs_n && !rd_n && wr_n;
  assign code   = reg_addr_e'(addr);

  always_comb begin
    stb = '0;
    stb.chan_acc = (wr_act || rd_act) && !addr[3];
    if (wr_act && addr[3]) begin
      unique case (code)
        RA_STAT_CMD:  stb.cmd_wr      = 1'b1;
        RA_REQ:       stb.req_wr      = 1'b1;
        RA_SMASK:     stb.smask_wr    = 1'b1;
        RA_MODE:      stb.mode_wr     = 1'b1;
        RA_PTR_CLR:   stb.ptr_clr     = 1'b1;
        RA_TEMP_MCLR: stb.mclr        = 1'b1;
        RA_MASK_CLR:  stb.mask_clr    = 1'b1;
        RA_MASK_ALL:  stb.mask_all_wr = 1'b1;
        default:      ;
      endcase
    end
    if (rd_act && addr[3]) begin
      stb.stat_rd = (code == RA_STAT_CMD);
      stb.temp_rd = (code == RA_TEMP_MCLR);
    end
  end

endmodule

// File: rtl/dmac_mask.sv
module dmac_mask #(
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              smask_wr,
  input  logic              mask_all_wr,
  input  logic              mask_clr,
  input  logic              req_wr,
  input  logic [NUM_CH-1:0] wdata_lo,
  input  logic [NUM_CH-1:0] end_evt,
  input  logic [NUM_CH-1:0] autoinit,
  input  logic [NUM_CH-1:0] dreq_raw,
  output logic [NUM_CH-1:0] mask_q,
  output logic [NUM_CH-1:0] req_q,
  output logic [NUM_CH-1:0] dreq_masked
);

  localparam int SEL_W   = $clog2(NUM_CH);
  localparam int SET_BIT = SEL_W;

  logic [NUM_CH-1:0] mask_n;
  logic [NUM_CH-1:0] req_n;
  logic [SEL_W-1:0]  sel;

  assign sel = wdata_lo[SEL_W-1:0];

  always_comb begin
    mask_n = mask_q;
    if (mask_all_wr) mask_n = wdata_lo;
    if (mask_clr)    mask_n = '0;
    if (smask_wr)    mask_n[sel] = wdata_lo[SET_BIT];
    mask_n = mask_n | (end_evt & ~autoinit);
  end

  always_comb begin
    req_n = req_q;
    if (req_wr) req_n[sel] = wdata_lo[SET_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      mask_q      <= '1;
      req_q       <= '0;
      dreq_masked <= '0;
    end else begin
      mask_q      <= mask_n;
      req_q       <= req_n;
      dreq_masked <= (dreq_raw | req_q) & ~mask_q;
    end
  end

endmodule

// File: rtl/dmac_status.sv
module dmac_status #(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mclr,
  input  logic              stat_rd,
  input  logic [NUM_CH-1:0] end_evt,
  input  logic              xfer_vld,
  input  logic [DW-1:0]     xfer_byte,
  output logic [NUM_CH-1:0] tc_q,
  output logic [DW-1:0]     temp_q
);

  logic [NUM_CH-1:0] tc_keep;

  assign tc_keep = stat_rd ? '0 : tc_q;

  always_ff @(posedge clk) begin
    if (rst || mclr) begin
      tc_q   <= '0;
      temp_q <= '0;
    end else begin
      tc_q <= tc_keep | end_evt;
      if (xfer_vld) temp_q <= xfer_byte;
    end
  end

endmodule

// File: rtl/dmac_regs.sv
module dmac_regs
  import dmac_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  rd_n,
  input  logic                  wr_n,
  input  logic [3:0]            addr,
  input  logic [DW-1:0]         wdata,
  output logic [DW-1:0]         rdata,
  input  logic [NUM_CH-1:0]     ch_tc,
  input  logic [NUM_CH-1:0]     ch_eop,
  input  logic [NUM_CH-1:0]     ch_autoinit,
  input  logic [NUM_CH-1:0]     dreq_raw,
  input  logic                  xfer_vld,
  input  logic [DW-1:0]         xfer_byte,
  output logic [NUM_CH-1:0]     dreq_masked,
  output logic [DW-1:0]         cmd_q,
  output logic [NUM_CH*(DW-$clog2(NUM_CH))-1:0] mode_bus,
  output logic                  byte_ptr,
  output logic                  idle_pulse
);

  localparam int SEL_W  = $clog2(NUM_CH);
  localparam int MODE_W = DW - SEL_W;

  strobe_t           stb;
  logic [NUM_CH-1:0] end_evt;
  logic [NUM_CH-1:0] mask_q;
  logic [NUM_CH-1:0] req_q;
  logic [NUM_CH-1:0] tc_q;
  logic [DW-1:0]     temp_q;
  logic [MODE_W-1:0] mode_q [NUM_CH];
  logic [DW-1:0]     rdata_n;
  logic              clr_all;

  assign end_evt = ch_tc | ch_eop;
  assign clr_all = rst || stb.mclr;

  dmac_decode u_dec (
    .cs_n (cs_n),
    .rd_n (rd_n),
    .wr_n (wr_n),
    .addr (addr),
    .stb  (stb)
  );

  dmac_mask #(.NUM_CH(NUM_CH)) u_mask (
    .clk         (clk),
    .rst         (rst),
    .mclr        (stb.mclr),
    .smask_wr    (stb.smask_wr),
    .mask_all_wr (stb.mask_all_wr),
    .mask_clr    (stb.mask_clr),
    .req_wr      (stb.req_wr),
    .wdata_lo    (wdata[NUM_CH-1:0]),
    .end_evt     (end_evt),
    .autoinit    (ch_autoinit),
    .dreq_raw    (dreq_raw),
    .mask_q      (mask_q),
    .req_q       (req_q),
    .dreq_masked (dreq_masked)
  );

  dmac_status #(.NUM_CH(NUM_CH), .DW(DW)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .mclr      (stb.mclr),
    .stat_rd   (stb.stat_rd),
    .end_evt   (end_evt),
    .xfer_vld  (xfer_vld),
    .xfer_byte (xfer_byte),
    .tc_q      (tc_q),
    .temp_q    (temp_q)
  );

  always_comb begin
    rdata_n = '0;
    if (stb.stat_rd)      rdata_n = DW'({dreq_raw | req_q, tc_q});
    else if (stb.temp_rd) rdata_n = temp_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= rdata_n;
  end

  always_ff @(posedge clk) begin
    idle_pulse <= clr_all;
    if (clr_all) begin
      cmd_q    <= '0;
      byte_ptr <= 1'b0;
    end else begin
      if (stb.cmd_wr)       cmd_q    <= wdata;
      if (stb.ptr_clr)      byte_ptr <= 1'b0;
      else if (stb.chan_acc) byte_ptr <= !byte_ptr;
    end
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_mode
    always_ff @(posedge clk) begin
      if (stb.mode_wr && (wdata[SEL_W-1:0] == SEL_W'(c)))
        mode_q[c] <= wdata[DW-1:SEL_W];
    end
    assign mode_bus[c*MODE_W +: MODE_W] = mode_q[c];
  end

endmodule

// File: rtl/dmac_regs_chk.sv
module dmac_regs_chk #(
  parameter int NUM_CH = 4,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              rd_n,
  input logic              wr_n,
  input logic [3:0]        addr,
  input logic [DW-1:0]     rdata,
  input logic [NUM_CH-1:0] ch_tc,
  input logic [NUM_CH-1:0] ch_eop,
  input logic [NUM_CH-1:0] ch_autoinit,
  input logic [NUM_CH-1:0] mask_q,
  input logic [NUM_CH-1:0] dreq_masked,
  input logic              byte_ptr,
  input logic              idle_pulse
);

  logic [NUM_CH-1:0] auto_set;
  logic              wr_act;
  logic              rd_act;
  logic              rd_wo;

  assign auto_set = (ch_tc | ch_eop) & ~ch_autoinit;
  assign wr_act   = !cs_n && !wr_n;
  assign rd_act   = !cs_n && !rd_n && wr_n;
  assign rd_wo    = rd_act && (!addr[3] || !(addr inside {4'h8, 4'hD}));

  AST_MCLR_MASKS: assert property (@(posedge clk) disable iff (rst)
    (wr_act && addr == 4'hD) |=> (mask_q == '1 && idle_pulse)); // R1

  AST_MASK_CLR_ALL: assert property (@(posedge clk) disable iff (rst)
    (wr_act && addr == 4'hE && auto_set == '0) |=> (mask_q == '0)); // R3

  AST_AUTO_MASK: assert property (@(posedge clk) disable iff (rst)
    (auto_set != '0) |=> ((mask_q & $past(auto_set)) == $past(auto_set))); // R4

  AST_GATED_REQ: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((dreq_masked & $past(mask_q)) == '0)); // R5

  AST_WO_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
    rd_wo |=> (rdata == '0)); // R11

  AST_PTR_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (wr_act && addr == 4'hC) |=> !byte_ptr); // R10

endmodule

bind dmac_regs dmac_regs_chk #(.NUM_CH(NUM_CH), .DW(DW)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cs_n        (cs_n),
  .rd_n        (rd_n),
  .wr_n        (wr_n),
  .addr        (addr),
  .rdata       (rdata),
  .ch_tc       (ch_tc),
  .ch_eop      (ch_eop),
  .ch_autoinit (ch_autoinit),
  .mask_q      (mask_q),
  .dreq_masked (dreq_masked),
  .byte_ptr    (byte_ptr),
  .idle_pulse  (idle_pulse)
);

// File: tb/dmac_regs_tb.sv
`timescale 1ns/1ps
module dmac_regs_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
  logic [3:0]  addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [3:0]  ch_tc = '0, ch_eop = '0, ch_autoinit = '0, dreq_raw = '0;
  logic        xfer_vld = 1'b0;
  logic [7:0]  xfer_byte = '0;
  logic [3:0]  dreq_masked;
  logic [7:0]  cmd_q;
  logic [23:0] mode_bus;
  logic        byte_ptr, idle_pulse;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [3:0] mask_m, req_m;
  logic [7:0] rv;

  always #2.5 clk = ~clk;

  dmac_regs u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
    .addr(addr), .wdata(wdata), .rdata(rdata),
    .ch_tc(ch_tc), .ch_eop(ch_eop), .ch_autoinit(ch_autoinit),
    .dreq_raw(dreq_raw), .xfer_vld(xfer_vld), .xfer_byte(xfer_byte),
    .dreq_masked(dreq_masked), .cmd_q(cmd_q), .mode_bus(mode_bus),
    .byte_ptr(byte_ptr), .idle_pulse(idle_pulse)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; wr_n = 1'b0; addr = a; wdata = d;
    @(negedge clk);
    cs_n = 1'b1; wr_n = 1'b1;
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = a;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1;
    d = rdata;
  endtask

  task automatic chk_masked(input logic [3:0] exp, input string req);
    @(negedge clk);
    check(dreq_masked == exp, req, dreq_masked, exp);
  endtask

  task automatic pulse_evt(input logic [3:0] tc, input logic [3:0] eop);
    @(negedge clk);
    ch_tc = tc; ch_eop = eop;
    @(negedge clk);
    ch_tc = '0; ch_eop = '0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    dreq_raw = 4'hF;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    chk_masked(4'h0, "R1 reset masks");
    check(cmd_q == 8'h00 && byte_ptr == 1'b0, "R1 reset cmd/ptr", {cmd_q, 7'b0, byte_ptr}, 0);
    rd(4'h8, rv); check(rv == 8'hF0, "R1 R7 reset status", rv, 8'hF0);
    rd(4'hD, rv); check(rv == 8'h00, "R1 reset temp", rv, 0);

    // R3: clear all masks ignoring data
    wr(4'hE, 8'hA5); mask_m = 4'h0;
    chk_masked(~mask_m, "R3 clear all masks");

    // R2: single mask sweep with junk upper bits
    for (int v = 0; v < 8; v++) begin
      wr(4'hA, {5'b10101, v[2:0]});
      mask_m[v[1:0]] = v[2];
      chk_masked(~mask_m, "R2 single mask");
    end

    // R3: write all mask bits, exhaustive
    for (int m = 0; m < 16; m++) begin
      wr(4'hF, {4'hA, m[3:0]});
      mask_m = m[3:0];
      chk_masked(~mask_m, "R3 all mask write");
    end

    // R6 R5: software requests
    dreq_raw = 4'h0; req_m = 4'h0;
    wr(4'hE, 8'h00); mask_m = 4'h0;
    for (int v = 0; v < 8; v++) begin
      wr(4'h9, {5'b11010, v[2:0]});
      req_m[v[1:0]] = v[2];
      chk_masked(req_m & ~mask_m, "R6 request write");
    end
    wr(4'hF, 8'h05); mask_m = 4'h5;
    chk_masked(req_m & ~mask_m, "R5 req gated by mask");
    for (int c = 0; c < 4; c++) wr(4'h9, 8'(c));
    req_m = 4'h0;

    // R7 R8: status
    dreq_raw = 4'b0010; ch_autoinit = 4'hF;
    pulse_evt(4'b0001, 4'b0100);
    rd(4'h8, rv); check(rv == 8'h25, "R7 R8 status tc/req", rv, 8'h25);
    rd(4'h8, rv); check(rv == 8'h20, "R8 clear on read", rv, 8'h20);
    @(negedge clk);
    cs_n = 1'b0; rd_n = 1'b0; addr = 4'h8; ch_tc = 4'b1000;
    @(negedge clk);
    cs_n = 1'b1; rd_n = 1'b1; ch_tc = '0; rv = rdata;
    check(rv == 8'h20, "R8 same-cycle read old", rv, 8'h20);
    rd(4'h8, rv); check(rv == 8'h28, "R8 same-cycle event kept", rv, 8'h28);
    rd(4'h8, rv);

    // R4: auto mask set on end of process
    dreq_raw = 4'hF; ch_autoinit = 4'b0011;
    wr(4'hE, 8'h00);
    pulse_evt(4'hF, 4'h0);
    @(negedge clk);
    check(dreq_masked == 4'b0011, "R4 auto mask", dreq_masked, 4'b0011);
    ch_autoinit = 4'hF;
    wr(4'hE, 8'h00);
    pulse_evt(4'h0, 4'b0100);
    @(negedge clk);
    check(dreq_masked == 4'hF, "R4 autoinit keeps mask", dreq_masked, 4'hF);
    rd(4'h8, rv);

    // R9: temporary register
    @(negedge clk); xfer_vld = 1'b1; xfer_byte = 8'h5A;
    @(negedge clk); xfer_vld = 1'b0; xfer_byte = 8'hFF;
    rd(4'hD, rv); check(rv == 8'h5A, "R9 temp read", rv, 8'h5A);
    rd(4'hD, rv); check(rv == 8'h5A, "R9 temp read again", rv, 8'h5A);

    // R11: reads of write-only addresses
    pulse_evt(4'b0010, 4'h0);
    wr(4'hF, 8'h06); mask_m = 4'h6;
    foreach (rv[i]) ;
    for (int a = 9; a < 16; a++) begin
      if (a == 13) continue;
      rd(4'(a), rv); check(rv == 8'h00, "R11 write-only read zero", rv, 0);
    end
    chk_masked(~mask_m, "R11 mask untouched");
    check(byte_ptr == 1'b0, "R11 ptr untouched", byte_ptr, 0);
    rd(4'h8, rv); check(rv == 8'hF2, "R11 status untouched", rv, 8'hF2);

    // R10: byte pointer
    rd(4'h3, rv); check(rv == 8'h00 && byte_ptr == 1'b1, "R10 R11 low read toggles", {rv, 7'b0, byte_ptr}, 1);
    wr(4'h2, 8'h11); check(byte_ptr == 1'b0, "R10 toggle back", byte_ptr, 0);
    wr(4'h6, 8'h11); check(byte_ptr == 1'b1, "R10 toggle again", byte_ptr, 1);
    wr(4'hC, 8'hFF); check(byte_ptr == 1'b0, "R10 clear ptr", byte_ptr, 0);

    // R13 R12: command and mode
    wr(4'h8, 8'h3C);
    check(cmd_q == 8'h3C, "R13 command", cmd_q, 8'h3C);
    for (int c = 0; c < 4; c++) wr(4'hB, {6'(8 * c + 5), 2'(c)});
    for (int c = 0; c < 4; c++)
      check(mode_bus[c*6 +: 6] == 6'(8 * c + 5), "R12 mode field", mode_bus[c*6 +: 6], 8 * c + 5);

    // R1: master clear
    wr(4'h9, 8'h05); wr(4'hE, 8'h00); wr(4'h1, 8'h00);
    pulse_evt(4'h0, 4'b0001);
    wr(4'hD, 8'h00);
    check(idle_pulse == 1'b1, "R1 idle pulse", idle_pulse, 1);
    check(cmd_q == 8'h00 && byte_ptr == 1'b0, "R1 mclr cmd/ptr", {cmd_q, 7'b0, byte_ptr}, 0);
    chk_masked(4'h0, "R1 mclr masks");
    check(idle_pulse == 1'b0, "R1 idle one cycle", idle_pulse, 0);
    dreq_raw = 4'h0;
    rd(4'h8, rv); check(rv == 8'h00, "R1 mclr status/req", rv, 0);
    rd(4'hD, rv); check(rv == 8'h00, "R1 mclr temp", rv, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule